// File: doc/BRIEF.md
# Instruction Cache Tag Directory

This block keeps the tags of a set-associative instruction cache and holds no data. Each fetch request carries a 64-bit address. The block splits the address into three fields: a line offset, which it ignores, a set index and a tag. The widths of these fields follow from three parameters: total capacity in bytes, number of ways and line length in bytes. All three must be powers of two, and the set count they imply must be at least two. A configuration that breaks either rule stops elaboration with an error.

Every way of the indexed set has its own comparator, and all of them work in parallel. One cycle after the request, the block reports whether the request hit and which way was chosen, as a one-hot vector. A miss completes in the same cycle, with no refill traffic. The block writes the new tag into a victim way and marks that way valid. The victim is the lowest-numbered invalid way of the set. If the set has no invalid way, the victim is the way named on the replacement-policy input. An external least-recently-used unit drives that input. To answer in the same cycle, it watches the combinational lookup-set output, and it keeps its own state current by following the one-cycle touch strobe that the block emits for every access.

Two saturating counters report the number of accesses and the number of hits.

Top module: `icache_tag_dir`

## Requirements
- R1: A synchronous reset (active-high `rst`) clears every valid bit and both counters and drops `respValid` and `touchValid`. After reset, every address misses.
- R2: The set index is `reqAddr[OFF_W+IDX_W-1:OFF_W]`, where OFF_W = log2(line bytes) and IDX_W = log2(sets). It appears combinationally on `lookupSet`. The tag is every address bit above the index, and all of those bits are compared. The offset bits have no effect on the outcome.
- R3: A request whose tag matches a valid way of its set gives `respHit`=1 in the next cycle. In the same cycle, `respWayOh` has exactly that way's bit set, where bit w means way w.
- R4: A request that matches no valid way gives `respHit`=0, and `respWayOh` names the victim way. The victim then holds the tag as valid, so the next request to the same line hits.
- R5: If the indexed set has an invalid way, a miss fills the lowest-numbered invalid way, and `repWay` is ignored.
- R6: If every way of the indexed set is valid, a miss replaces the way whose binary number is on `repWay`.
- R7: Every request raises `touchValid` for exactly the following cycle. During that cycle, `touchSet` carries the request's set index and `touchWay` carries the binary number of the hit way or victim way.
- R8: `accessCount` increases by one for each request and `hitCount` by one for each hit. Each counter stops at its all-ones value.
- R9: Cycles without `reqValid` change no directory state and no counter, and they raise neither `respValid` nor `touchValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Fetch request strobe |
| reqAddr | input | ADDR_W | Fetch address |
| lookupSet | output | IDX_W | Set index of the current request, combinational |
| repWay | input | WAY_W | Victim way chosen by the replacement unit for `lookupSet` |
| respValid | output | 1 | Response valid, one cycle after a request |
| respHit | output | 1 | The request hit |
| respWayOh | output | WAYS | One-hot hit or victim way |
| touchValid | output | 1 | Strobe to the replacement unit |
| touchSet | output | IDX_W | Set that was touched |
| touchWay | output | WAY_W | Way that was touched |
| hitCount | output | CNT_W | Saturating hit count |
| accessCount | output | CNT_W | Saturating access count |

## Verification
The bench builds the block with four sets of four ways, 16-byte lines and 4-bit counters. With this configuration it can fill and then hit every way of every set, and it drives every value of `repWay` against full sets. The 4-bit counters reach saturation within a few dozen requests, so both the stop at all-ones and the increments before it are checked. Tags that differ only in address bit 63 show that the tag compare covers the full width.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  // Strobes from control to datapath for one request cycle
  typedef struct packed {
    logic access;
    logic hit;
    logic fill;
  } tagdir_strobe_t;

  function automatic bit isPow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/tagdir_satcnt.sv
module tagdir_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)                      count <= '0;
    else if (inc && count != '1)  count <= count + 1'b1;
  end

  AST_CNT_STAYS_SAT: assert property (@(posedge clk) disable iff (rst)
    (count == '1) |=> (count == '1));                                   // R8
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));                                           // R9

endmodule

// File: rtl/tagdir_dp.sv
module tagdir_dp
  import tagdir_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SETS   = 2,
  parameter int WAYS   = 4,
  parameter int OFF_W  = 7,
  parameter int IDX_W  = 1,
  parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reqAddr,
  input  tagdir_strobe_t    strobe,
  input  logic [WAYS-1:0]   victimOh,
  output logic [IDX_W-1:0]  setIdx,
  output logic [WAYS-1:0]   wayValid,
  output logic [WAYS-1:0]   wayMatch
);

  logic [WAYS-1:0]  validArr [SETS];
  logic [TAG_W-1:0] tagArr   [SETS][WAYS];
  logic [TAG_W-1:0] addrTag;

  assign setIdx  = reqAddr[OFF_W+IDX_W-1:OFF_W];
  assign addrTag = reqAddr[ADDR_W-1:OFF_W+IDX_W];

  // one comparator per way
  generate
    for (genvar w = 0; w < WAYS; w++) begin : gCmp
      assign wayValid[w] = validArr[setIdx][w];
      assign wayMatch[w] = validArr[setIdx][w] && (tagArr[setIdx][w] == addrTag);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) validArr[s] <= '0;
    end else if (strobe.fill) begin
      for (int w = 0; w < WAYS; w++) begin
        if (victimOh[w]) begin
          validArr[setIdx][w] <= 1'b1;
          tagArr[setIdx][w]   <= addrTag;
        end
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wayMatch));                                                // R3

endmodule

// File: rtl/tagdir_ctl.sv
module tagdir_ctl
  import tagdir_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int IDX_W = 1,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [WAYS-1:0]  wayMatch,
  input  logic [WAYS-1:0]  wayValid,
  input  logic [IDX_W-1:0] setIdx,
  input  logic [WAY_W-1:0] repWay,
  output tagdir_strobe_t   strobe,
  output logic [WAYS-1:0]  victimOh,
  output logic             respValid,
  output logic             respHit,
  output logic [WAYS-1:0]  respWayOh,
  output logic [IDX_W-1:0] touchSet,
  output logic [WAY_W-1:0] touchWay
);

  logic [WAYS-1:0]  freeOh, repOh, selOh;
  logic [WAY_W-1:0] selBin;
  logic             anyHit, anyFree;

  assign anyHit  = |wayMatch;
  assign anyFree = ~&wayValid;

  // lowest-numbered invalid way wins
  always_comb begin
    freeOh = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!wayValid[w]) freeOh = {{(WAYS-1){1'b0}}, 1'b1} << w;
    end
  end

  // decoded replacement choice
  generate
    for (genvar w = 0; w < WAYS; w++) begin : gRep
      assign repOh[w] = (WAYS == 1) || (repWay == WAY_W'(w));
    end
  endgenerate

  assign victimOh = anyFree ? freeOh : repOh;
  assign selOh    = anyHit ? wayMatch : victimOh;

  always_comb begin
    selBin = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (selOh[w]) selBin = selBin | WAY_W'(w);
    end
  end

  assign strobe.access = reqValid;
  assign strobe.hit    = reqValid && anyHit;
  assign strobe.fill   = reqValid && !anyHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respWayOh <= '0;
      touchSet  <= '0;
      touchWay  <= '0;
    end else begin
      respValid <= strobe.access;
      if (strobe.access) begin
        respHit   <= strobe.hit;
        respWayOh <= selOh;
        touchSet  <= setIdx;
        touchWay  <= selBin;
      end
    end
  end

  AST_WAY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    respValid |-> ($countones(respWayOh) == 1));                        // R3
  AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (rst)
    (strobe.fill && !(&wayValid)) |-> ((victimOh & wayValid) == '0));   // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !respValid);                                          // R9

endmodule

// File: rtl/icache_tag_dir.sv
module icache_tag_dir
  import tagdir_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 128,
  parameter int CNT_W       = 32,
  localparam int SETS  = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [IDX_W-1:0]  lookupSet,
  input  logic [WAY_W-1:0]  repWay,
  output logic              respValid,
  output logic              respHit,
  output logic [WAYS-1:0]   respWayOh,
  output logic              touchValid,
  output logic [IDX_W-1:0]  touchSet,
  output logic [WAY_W-1:0]  touchWay,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  accessCount
);

  generate
    if (!isPow2(CACHE_BYTES) || !isPow2(WAYS) || !isPow2(LINE_BYTES)) begin : gBadPow2
      $error("cache size, way count and line size must be powers of two");
    end
    if (SETS < 2) begin : gBadSets
      $error("configuration must give at least two sets");
    end
  endgenerate

  tagdir_strobe_t  strobe;
  logic [WAYS-1:0] victimOh, wayValid, wayMatch;
  logic [IDX_W-1:0] setIdx;

  tagdir_dp #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
    .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_dp (
    .clk(clk), .rst(rst), .reqAddr(reqAddr), .strobe(strobe),
    .victimOh(victimOh), .setIdx(setIdx), .wayValid(wayValid), .wayMatch(wayMatch)
  );

  tagdir_ctl #(
    .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .wayMatch(wayMatch),
    .wayValid(wayValid), .setIdx(setIdx), .repWay(repWay), .strobe(strobe),
    .victimOh(victimOh), .respValid(respValid), .respHit(respHit),
    .respWayOh(respWayOh), .touchSet(touchSet), .touchWay(touchWay)
  );

  tagdir_satcnt #(.W(CNT_W)) u_accCnt (
    .clk(clk), .rst(rst), .inc(strobe.access), .count(accessCount)
  );

  tagdir_satcnt #(.W(CNT_W)) u_hitCnt (
    .clk(clk), .rst(rst), .inc(strobe.hit), .count(hitCount)
  );

  assign lookupSet  = setIdx;
  assign touchValid = respValid;

  AST_REQ_TOUCHES: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (respValid && touchValid));                            // R7
  AST_HIT_LE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    hitCount <= accessCount);                                           // R8

endmodule

// File: tb/icache_tag_dir_tb.sv
`timescale 1ns/1ps
module icache_tag_dir_tb;

  localparam int AW = 64, CB = 256, NW = 4, LB = 16, CW = 4;
  localparam int NS = 4, OW = 4, IW = 2, WW = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, reqValid, respValid, respHit, touchValid;
  logic [AW-1:0] reqAddr;
  logic [IW-1:0] lookupSet, touchSet;
  logic [WW-1:0] repWay, touchWay;
  logic [NW-1:0] respWayOh;
  logic [CW-1:0] hitCount, accessCount;

  icache_tag_dir #(
    .ADDR_W(AW), .CACHE_BYTES(CB), .WAYS(NW), .LINE_BYTES(LB), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .lookupSet(lookupSet), .repWay(repWay), .respValid(respValid),
    .respHit(respHit), .respWayOh(respWayOh), .touchValid(touchValid),
    .touchSet(touchSet), .touchWay(touchWay), .hitCount(hitCount),
    .accessCount(accessCount)
  );

  int nCmp = 0, nBad = 0;
  bit            mValid [NS][NW];
  logic [AW-1:0] mTag   [NS][NW];
  int expAcc = 0, expHit = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkAddr(input logic [AW-1:0] tag, input int s, input int off);
    return (tag << (OW + IW)) | (AW'(s) << OW) | AW'(off);
  endfunction

  task automatic doReset();
    rst = 1'b1; reqValid = 1'b0; reqAddr = '0; repWay = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) mValid[s][w] = 1'b0;
    expAcc = 0; expHit = 0;
    chk("R1", "respValid", 64'(respValid), 64'd0);
    chk("R1", "touchValid", 64'(touchValid), 64'd0);
    chk("R1", "accessCount", 64'(accessCount), 64'd0);
    chk("R1", "hitCount", 64'(hitCount), 64'd0);
  endtask

  // caller is at a falling edge; leaves the bench at the next falling edge
  task automatic access(input logic [AW-1:0] addr, input int rep, input string req);
    int s, w;
    bit h;
    logic [AW-1:0] t;
    s = int'(addr[OW+IW-1:OW]);
    t = addr >> (OW + IW);
    h = 1'b0; w = -1;
    for (int i = 0; i < NW; i++)
      if (mValid[s][i] && mTag[s][i] == t) begin h = 1'b1; w = i; end
    if (!h) begin
      for (int i = NW - 1; i >= 0; i--) if (!mValid[s][i]) w = i;
      if (w < 0) w = rep;
    end
    reqValid = 1'b1; reqAddr = addr; repWay = WW'(rep);
    #1;
    chk("R2", "lookupSet", 64'(lookupSet), 64'(s));
    @(negedge clk);
    if (expAcc < CMAX) expAcc++;
    if (h && expHit < CMAX) expHit++;
    if (!h) begin mValid[s][w] = 1'b1; mTag[s][w] = t; end
    chk(req, "respValid", 64'(respValid), 64'd1);
    chk(req, "respHit", 64'(respHit), 64'(h));
    chk(req, "respWayOh", 64'(respWayOh), 64'(1) << w);
    chk("R7", "touchValid", 64'(touchValid), 64'd1);
    chk("R7", "touchSet", 64'(touchSet), 64'(s));
    chk("R7", "touchWay", 64'(touchWay), 64'(w));
    chk("R8", "accessCount", 64'(accessCount), 64'(expAcc));
    chk("R8", "hitCount", 64'(hitCount), 64'(expHit));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      reqValid = 1'b0; reqAddr = mkAddr(64'h10, i % NS, 0); repWay = WW'(i);
      @(negedge clk);
      chk("R9", "respValid", 64'(respValid), 64'd0);
      chk("R9", "touchValid", 64'(touchValid), 64'd0);
      chk("R9", "accessCount", 64'(accessCount), 64'(expAcc));
      chk("R9", "hitCount", 64'(hitCount), 64'(expHit));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    doReset();
    // R5: empty sets fill ways in order, repWay held at 3 is ignored
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NW; k++) access(mkAddr(64'h10 + 64'(k), s, k), 3, "R5");
    // R3/R2: every line hits, offset changed
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NW; k++) access(mkAddr(64'h10 + 64'(k), s, 15 - k), 0, "R3");
    // R2: tag differs only in bit 63 -> miss, full set uses repWay
    access(mkAddr(64'h10, 0, 0) | (64'h1 << 63), 2, "R2");
    access(mkAddr(64'h12, 0, 0), 1, "R4");
    access(mkAddr(64'h12, 0, 3), 0, "R4");
    // R6: every repWay value against full sets
    for (int s = 1; s < NS; s++)
      for (int r = 0; r < NW; r++) access(mkAddr(64'h40 + 64'(4 * s + r), s, 0), r, "R6");
    for (int s = 1; s < NS; s++)
      for (int r = 0; r < NW; r++) access(mkAddr(64'h40 + 64'(4 * s + r), s, 8), 0, "R3");
    reqValid = 1'b0;
    idle(3);
    // R1: reset mid-run, previously resident line misses into way 0
    doReset();
    access(mkAddr(64'h45, 1, 0), 3, "R1");
    // R8: hit counter runs into saturation
    for (int i = 0; i < 20; i++) access(mkAddr(64'h45, 1, i % LB), 2, "R8");
    reqValid = 1'b0;
    idle(2);
    summary();
  end

endmodule